// File: doc/BRIEF.md
# DS3/E3 Transmit Line Output Formatter

This block sits at the line edge of a DS3/E3 transmitter. It keeps the bit position inside the outbound frame and shows it to the upstream frame builder. The builder answers with the serial data bit for that position. The block registers each bit onto a pair of line rails. In single-rail mode the positive rail carries the data and the negative rail is an end-of-frame strobe, one bit wide. In dual-rail mode the rails carry alternate-mark-inversion pulse commands: each one bit goes to the opposite rail from the one before it, and a zero drives neither rail.

Frame timing either runs free or follows an external frame reference. In free-running mode the position counter wraps at the length of the selected format. In slave mode the block stays idle until the reference rises. Each rising edge of the reference, seen through a two-flop synchronizer, then restarts the frame at position zero. A configuration bit chooses whether the rails change on the rising edge or on the falling edge of the transmit clock.

Top module: `tx_line_fmt`

## Requirements
- R1: While rst_ni is low, line_pos_o, line_neg_o and frame_valid_o are 0 and frame_pos_o is 0.
- R2: In free mode (cfg_slave_i=0), frame_valid_o is 1 from the first rising clock edge after reset. frame_pos_o starts at 0, rises by one each cycle and wraps to 0 after length-1. The length is set by cfg_fmt_i: 00 gives 4760, 01 gives 1536, 10 gives 4296 and 11 gives 4760.
- R3: In single-rail mode (cfg_bipolar_i=0), line_pos_o one cycle later equals the tx_data_i presented while frame_pos_o showed a valid position.
- R4: In single-rail mode, line_neg_o is 1 for exactly the bit of position length-1 and is 0 for every other bit.
- R5: In dual-rail mode (cfg_bipolar_i=1), each data one sets exactly one rail high for one bit. Successive ones alternate between the rails, and the first one after reset goes on line_pos_o. A zero leaves both rails low.
- R6: line_pos_o and line_neg_o are never both 1 in dual-rail mode.
- R7: With cfg_fall_i=0 the rails change on the rising clock edge. With cfg_fall_i=1 they change on the falling edge that follows, half a cycle later.
- R8: In slave mode (cfg_slave_i=1), frame_valid_o and both rails stay 0 until the first rising edge of frame_ref_i. If frame_ref_i rises after clock edge k, frame_pos_o is 0 and frame_valid_o is 1 after rising edge k+3.
- R9: In slave mode, frame_ref_i held high restarts the frame only once. A later rising edge in the middle of a frame restarts it at 0. With no reference edge the counter wraps at the format length.
- R10: In free mode, pulses on frame_ref_i do not change the frame_pos_o sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit line clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_bipolar_i | input | 1 | 1: dual-rail AMI output, 0: single-rail output with end-of-frame strobe |
| cfg_slave_i | input | 1 | 1: frame timing follows frame_ref_i, 0: free running |
| cfg_fmt_i | input | 2 | Frame format: 00 DS3, 01 E3 G.751, 10 E3 G.832, 11 DS3 |
| cfg_fall_i | input | 1 | 1: rails change on the falling clock edge |
| tx_data_i | input | 1 | Serial data bit for the current frame_pos_o |
| frame_ref_i | input | 1 | Asynchronous frame reference, acts on its rising edge |
| frame_valid_o | output | 1 | A frame is in progress and frame_pos_o is valid |
| frame_pos_o | output | 13 | Current bit position in the frame |
| line_pos_o | output | 1 | Positive rail, or single-rail data |
| line_neg_o | output | 1 | Negative rail, or end-of-frame strobe |

## Verification
Every format runs through full frames and past the wrap. Pseudo-random, all-ones, alternating and all-zero data are used. All-ones exposes AMI alternation, zeros confirm that no pulse is sent, and random data separates the rail mapping from the end-of-frame strobe. Each run samples the rails at both a quarter and three quarters of the clock period, which tells the rising-edge update from the falling-edge one. The reference patterns cover an idle start, a level held high, a restart in the middle of a frame, a long gap that forces a self-wrap, and pulses applied in free mode, where they must be ignored.

// File: rtl/tx_line_pkg.sv
package tx_line_pkg;
  typedef enum logic [1:0] {
    FMT_DS3  = 2'b00,
    FMT_G751 = 2'b01,
    FMT_G832 = 2'b10,
    FMT_RSV  = 2'b11
  } fmt_e;
endpackage

// File: rtl/tx_ref_edge.sv
module tx_ref_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/tx_frame_ctr.sv
module tx_frame_ctr
  import tx_line_pkg::*;
#(
  parameter int unsigned DS3_BITS  = 4760,
  parameter int unsigned G751_BITS = 1536,
  parameter int unsigned G832_BITS = 4296,
  parameter int unsigned CNT_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  fmt_e             fmt_i,
  input  logic             restart_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic             force_zero;

  always_comb begin
    unique case (fmt_i)
      FMT_G751: len_m1 = CNT_W'(G751_BITS - 1);
      FMT_G832: len_m1 = CNT_W'(G832_BITS - 1);
      default:  len_m1 = CNT_W'(DS3_BITS - 1);
    endcase
  end

  assign force_zero = slave_i & restart_i;
  assign last_o     = act_q & (cnt_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (force_zero) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (!act_q) begin
      // free mode starts on the first edge, slave waits for the reference
      cnt_q <= '0;
      act_q <= ~slave_i;
    end else if (last_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = act_q;
  assign cnt_o    = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_m1); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !force_zero) |=> cnt_q == '0); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !last_o && !force_zero) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_SLAVE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_zero |=> (act_q && cnt_q == '0)); // R8
  AST_SLAVE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && !act_q && !restart_i) |=> !act_q); // R8
endmodule

// File: rtl/tx_rail_enc.sv
module tx_rail_enc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bipolar_i,
  input  logic active_i,
  input  logic last_i,
  input  logic data_i,
  output logic pos_o,
  output logic neg_o
);
  logic pos_q, neg_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
      pol_q <= 1'b0;
    end else if (!active_i) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (bipolar_i) begin
      pos_q <= data_i & ~pol_q;
      neg_q <= data_i & pol_q;
      if (data_i) pol_q <= ~pol_q;
    end else begin
      pos_q <= data_i;
      neg_q <= last_i;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  AST_RAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bipolar_i |-> !(pos_q && neg_q)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!pos_q && !neg_q)); // R8
  AST_AMI_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bipolar_i && active_i && data_i && pos_q) |=> neg_q); // R5
  AST_AMI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bipolar_i && active_i && !data_i) |=> (!pos_q && !neg_q)); // R5
endmodule

// File: rtl/tx_edge_sel.sv
module tx_edge_sel #(
  parameter int unsigned RAILS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic [RAILS-1:0] rail_i,
  output logic [RAILS-1:0] rail_o
);
  for (genvar g = 0; g < RAILS; g++) begin : g_rail
    logic fall_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fall_q <= 1'b0;
      else         fall_q <= rail_i[g];
    end
    assign rail_o[g] = fall_i ? fall_q : rail_i[g];
  end

  AST_FALL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |-> rail_o == rail_i); // R7
endmodule

// File: rtl/tx_line_fmt.sv
module tx_line_fmt
  import tx_line_pkg::*;
#(
  parameter int unsigned DS3_BITS    = 4760,
  parameter int unsigned G751_BITS   = 1536,
  parameter int unsigned G832_BITS   = 4296,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MAX_BITS   = (DS3_BITS > G832_BITS) ?
                                       ((DS3_BITS > G751_BITS) ? DS3_BITS : G751_BITS) :
                                       ((G832_BITS > G751_BITS) ? G832_BITS : G751_BITS),
  localparam int unsigned CNT_W      = $clog2(MAX_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_bipolar_i,
  input  logic             cfg_slave_i,
  input  logic [1:0]       cfg_fmt_i,
  input  logic             cfg_fall_i,
  input  logic             tx_data_i,
  input  logic             frame_ref_i,
  output logic             frame_valid_o,
  output logic [CNT_W-1:0] frame_pos_o,
  output logic             line_pos_o,
  output logic             line_neg_o
);
  logic ref_rise, active, last, enc_pos, enc_neg;
  logic [1:0] rails;

  tx_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (frame_ref_i),
    .rise_o(ref_rise)
  );

  tx_frame_ctr #(
    .DS3_BITS (DS3_BITS),
    .G751_BITS(G751_BITS),
    .G832_BITS(G832_BITS),
    .CNT_W    (CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slave_i  (cfg_slave_i),
    .fmt_i    (fmt_e'(cfg_fmt_i)),
    .restart_i(ref_rise),
    .active_o (active),
    .cnt_o    (frame_pos_o),
    .last_o   (last)
  );

  tx_rail_enc u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bipolar_i(cfg_bipolar_i),
    .active_i (active),
    .last_i   (last),
    .data_i   (tx_data_i),
    .pos_o    (enc_pos),
    .neg_o    (enc_neg)
  );

  tx_edge_sel #(.RAILS(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fall_i(cfg_fall_i),
    .rail_i({enc_neg, enc_pos}),
    .rail_o(rails)
  );

  assign frame_valid_o = active;
  assign line_pos_o    = rails[0];
  assign line_neg_o    = rails[1];

  AST_UNI_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_bipolar_i && enc_neg) |-> $past(last)); // R4
endmodule

// File: tb/tx_line_fmt_tb.sv
module tx_line_fmt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bip = 1'b0, slv = 1'b0, fall = 1'b0, data = 1'b0, fref = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic valid, lpos, lneg;
  logic [12:0] fpos;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_line_fmt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_bipolar_i(bip), .cfg_slave_i(slv),
    .cfg_fmt_i(fmt), .cfg_fall_i(fall), .tx_data_i(data), .frame_ref_i(fref),
    .frame_valid_o(valid), .frame_pos_o(fpos), .line_pos_o(lpos), .line_neg_o(lneg)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int flen(input logic [1:0] f);
    case (f)
      2'b01:   return 1536;
      2'b10:   return 4296;
      default: return 4760;
    endcase
  endfunction

  // reference schedule: two high windows
  int ra_s, ra_l, rb_s, rb_l;
  function automatic bit ref_at(input int i);
    return (i >= ra_s && i < ra_s + ra_l) || (i >= rb_s && i < rb_s + rb_l);
  endfunction

  task automatic do_reset(input logic b, input logic s, input logic [1:0] f, input logic fe);
    @(posedge clk); #3.75;
    rst_n = 1'b0; bip = b; slv = s; fmt = f; fall = fe; data = 1'b0; fref = 1'b0;
    repeat (3) @(posedge clk);
    #3.75;
    rst_n = 1'b1;
  endtask

  // pat: 0 zeros, 1 ones, 2 alternating, 3 lfsr
  task automatic run(input int n, input int pat, input string ctag);
    int len = flen(fmt);
    bit m_valid = 0, p_valid = 0, p_data = 0, pol = 0;
    int m_cnt = 0, p_cnt = 0;
    bit e_pos = 0, e_neg = 0, o_pos = 0, o_neg = 0;
    logic q_pos, q_neg;
    logic [4:1] rq = '0;
    logic [15:0] lf = 16'hACE1;
    string rtag;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1.25;
      q_pos = lpos; q_neg = lneg;
      #2.5;
      // counter model
      if (slv && rq[3] && !rq[4]) begin m_valid = 1; m_cnt = 0; end
      else if (!m_valid) begin m_valid = !slv; m_cnt = 0; end
      else m_cnt = (m_cnt == len - 1) ? 0 : m_cnt + 1;
      // rail model from previous inputs
      o_pos = e_pos; o_neg = e_neg;
      if (!p_valid) begin e_pos = 0; e_neg = 0; end
      else if (bip) begin
        e_pos = p_data & ~pol; e_neg = p_data & pol;
        if (p_data) pol = ~pol;
      end else begin
        e_pos = p_data; e_neg = (p_cnt == len - 1);
      end
      rtag = bip ? "R5" : "R3";
      if (slv && !m_valid) rtag = "R8";
      chk(lpos === e_pos, rtag, "pos rail", lpos, e_pos);
      chk(lneg === e_neg, bip ? "R5" : (slv && !m_valid) ? "R8" : "R4", "neg rail", lneg, e_neg);
      if (bip) chk(!(lpos && lneg), "R6", "both rails", {lpos, lneg}, 0);
      if (fall) begin
        chk(q_pos === o_pos && q_neg === o_neg, "R7", "rails before falling edge",
            {q_pos, q_neg}, {o_pos, o_neg});
      end else begin
        chk(q_pos === e_pos && q_neg === e_neg, "R7", "rails after rising edge",
            {q_pos, q_neg}, {e_pos, e_neg});
      end
      chk(valid === m_valid, ctag, "frame valid", valid, m_valid);
      chk(fpos == 13'(m_cnt), ctag, "frame position", fpos, m_cnt);
      // stimulus
      case (pat)
        0: data = 1'b0;
        1: data = 1'b1;
        2: data = i[0];
        default: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; data = lf[0]; end
      endcase
      fref = ref_at(i);
      rq = {rq[3:1], fref};
      p_valid = m_valid; p_cnt = m_cnt; p_data = data;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ra_s = -10; ra_l = 0; rb_s = -10; rb_l = 0;
    // R1: reset state
    repeat (2) @(posedge clk); #3.75;
    data = 1'b1;
    chk(lpos === 1'b0 && lneg === 1'b0, "R1", "rails in reset", {lpos, lneg}, 0);
    chk(valid === 1'b0, "R1", "valid in reset", valid, 0);
    chk(fpos == 13'd0, "R1", "position in reset", fpos, 0);

    do_reset(0, 0, 2'b00, 0); run(2 * 4760 + 20, 3, "R2");
    do_reset(0, 0, 2'b01, 1); run(2 * 1536 + 10, 2, "R2");
    do_reset(0, 0, 2'b10, 0); run(4296 + 10, 1, "R2");
    do_reset(0, 0, 2'b11, 1); run(4760 + 5, 3, "R2");
    do_reset(1, 0, 2'b01, 0); run(400, 1, "R2");
    do_reset(1, 0, 2'b01, 0); run(1600, 3, "R2");
    do_reset(1, 0, 2'b01, 1); run(1600, 3, "R2");
    do_reset(1, 0, 2'b01, 1); run(200, 0, "R2");
    // R10: reference pulses ignored in free mode
    ra_s = 100; ra_l = 5; rb_s = 700; rb_l = 1;
    do_reset(0, 0, 2'b01, 0); run(2000, 3, "R10");
    // R8/R9: slave mode idle, held level, mid-frame restart, self wrap
    ra_s = 50; ra_l = 30; rb_s = 900; rb_l = 1;
    do_reset(0, 1, 2'b01, 0); run(2700, 3, "R9");
    ra_s = 10; ra_l = 2; rb_s = -10; rb_l = 0;
    do_reset(1, 1, 2'b01, 1); run(500, 1, "R8");
    ra_s = 20; ra_l = 3; rb_s = 4000; rb_l = 2;
    do_reset(0, 1, 2'b10, 0); run(4600, 3, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule